// File: doc/BRIEF.md
# Tag Command Frame Receiver

This block sits behind the envelope detector of a low-frequency tag. It takes the demodulated, logic-level line and passes it through a two-flop synchronizer and a majority-vote filter that runs at the decoder tick rate. It then recovers Manchester bits by sampling at fixed offsets from the first falling edge of a frame. It hunts for a fixed start pattern and stores every later bit until the line stops toggling. The stored bits are split into a flags field, a command code, a parameter byte, a variable data field and a trailing 16-bit check value.

The check value is verified when the frame ends. A good frame releases its fields together with a one-cycle valid strobe. A bad, short or oversized frame raises a one-cycle error strobe, and the previously released fields stay as they were. After either strobe the receiver ignores the line until the controller raises `ready_i`.

The decoder tick comes from a divider of the system clock. The default divider gives 1 MHz from 125 MHz. Tick rate, half-bit length, vote width, data capacity and start pattern are all parameters.

Top module: `cmdrx_top`

## Requirements
- R1: While reset is applied and after its release, `frame_valid_o`, `crc_err_o` and `sof_found_o` are 0, and `flags_o`, `cmd_o`, `param_o`, `data_o` and `data_len_o` are all zero.
- R2: Line coding is Manchester with the line idle high. A 1 is sent as high then low, and a 0 as low then high, each half lasting `HALF_TICKS` ticks. A disturbance that spans fewer than `TICK_DIV` clocks, once per half-bit, does not change any decoded bit.
- R3: A frame begins with the start pattern `SOF_PAT`, sent first bit first (default 0,0,1). `sof_found_o` rises once the whole pattern is matched. A mismatching bit returns the block to hunting, and no strobe follows.
- R4: After the start pattern, bits arrive most significant first: 5 flag bits to `flags_o`, 6 command bits to `cmd_o`, 8 parameter bits to `param_o`, then data, then 16 check bits.
- R5: The check is CRC-16 with polynomial 0x1021 and preset 0xFFFF, no final inversion, run over flags through check bits. It is good when the remainder is 0x0000. A good frame gives exactly one cycle of `frame_valid_o`, and the fields are updated in that same cycle.
- R6: A frame whose check fails gives exactly one cycle of `crc_err_o`, never together with `frame_valid_o`. All field outputs keep their previous values.
- R7: A frame that ends with fewer than 35 bits after the start pattern is reported through `crc_err_o`.
- R8: A frame whose data field is longer than `MAX_DATA` (64) bits is reported through `crc_err_o`, even if its check value is correct.
- R9: The data field may have any length from 0 to `MAX_DATA` bits. It is presented right-aligned in `data_o` with zero padding above it, and its length appears in `data_len_o`.
- R10: After either strobe, no further frame is reported until `ready_i` has been seen high. A frame sent during that wait is dropped.
- R11: The frame ends when a bit period has two equal halves, for example when the line returns to idle high. No strobe appears before that bit period has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Demodulated line from the envelope detector |
| ready_i | input | 1 | Controller acknowledge; re-arms reception |
| flags_o | output | 5 | Flags of the last good frame |
| cmd_o | output | 6 | Command code of the last good frame |
| param_o | output | 8 | Parameter byte of the last good frame |
| data_o | output | MAX_DATA | Data field, right-aligned |
| data_len_o | output | $clog2(MAX_DATA+1) | Data field length in bits |
| frame_valid_o | output | 1 | One-cycle strobe: good frame |
| crc_err_o | output | 1 | One-cycle strobe: bad, short or oversized frame |
| sof_found_o | output | 1 | High from start-pattern match until re-armed |

## Verification
Good frames are sent with data lengths of 16, 0 and 64 bits and with alternating and sparse values. These show whether field boundaries and right-alignment hold at the empty and full extremes. A single flipped check bit, a frame cut off before its check field, and a 65-bit data field with a correct check value separate the three error causes, and each one must leave the earlier fields in place. A wrong start pattern followed by idle shows that hunting rejects it without any report. A frame carrying a short glitch in every half-bit shows that the vote absorbs it. Holding `ready_i` low across a second frame shows that the block really ignores input while it waits for the controller.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int FLAG_W = 5;
  localparam int CMD_W  = 6;
  localparam int PARM_W = 8;
  localparam int CRC_W  = 16;
  localparam int HDR_W  = FLAG_W + CMD_W + PARM_W;
  localparam logic [CRC_W-1:0] CRC_POLY    = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'h0000;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_CAP   = 3'd1,
    ST_CHECK = 3'd2,
    ST_HOLD  = 3'd3,
    ST_ABORT = 3'd4
  } frame_st_e;
endpackage

// File: rtl/cmdrx_tick.sv
module cmdrx_tick #(
  parameter int DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cmdrx_filter.sv
module cmdrx_filter #(
  parameter int VOTE_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  output logic filt_o
);
  logic [1:0]        sync_q;
  logic [VOTE_N-1:0] smp_q, smp_d;

  always_comb begin
    smp_d = smp_q;
    if (tick_i) smp_d = {smp_q[VOTE_N-2:0], sync_q[1]};
  end

  always_comb begin
    int ones;
    ones = 0;
    for (int i = 0; i < VOTE_N; i++) ones += int'(smp_q[i]);
    filt_o = (ones > VOTE_N / 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      smp_q  <= '1;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      smp_q  <= smp_d;
    end
  end
endmodule

// File: rtl/cmdrx_mdec.sv
module cmdrx_mdec #(
  parameter int HALF = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic din_i,
  input  logic clr_i,
  output logic bit_stb_o,
  output logic bit_o,
  output logic viol_o
);
  localparam int PH_W = $clog2(2 * HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF - 1);
  localparam logic [PH_W-1:0] PH_S1   = PH_W'(HALF / 2);
  localparam logic [PH_W-1:0] PH_S2   = PH_W'(HALF + HALF / 2);

  logic            run_q, run_d;
  logic            prev_q, prev_d;
  logic            h1_q, h1_d;
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    run_d     = run_q;
    ph_d      = ph_q;
    h1_d      = h1_q;
    prev_d    = tick_i ? din_i : prev_q;
    bit_stb_o = 1'b0;
    bit_o     = h1_q;
    viol_o    = 1'b0;
    if (clr_i) begin
      run_d = 1'b0;
    end else if (tick_i) begin
      if (!run_q) begin
        if (prev_q && !din_i) begin
          run_d = 1'b1;
          ph_d  = PH_W'(1);
        end
      end else begin
        ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        if (ph_q == PH_S1) h1_d = din_i;
        if (ph_q == PH_S2) begin
          if (din_i == h1_q) begin
            viol_o = 1'b1;
            run_d  = 1'b0;
          end else begin
            bit_stb_o = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      prev_q <= 1'b1;
      h1_q   <= 1'b0;
      ph_q   <= '0;
    end else begin
      run_q  <= run_d;
      prev_q <= prev_d;
      h1_q   <= h1_d;
      ph_q   <= ph_d;
    end
  end
endmodule

// File: rtl/cmdrx_crc.sv
module cmdrx_crc
  import cmdrx_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  always_comb begin
    fb    = crc_i[CRC_W-1] ^ bit_i;
    crc_o = {crc_i[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/cmdrx_top.sv
module cmdrx_top
  import cmdrx_pkg::*;
#(
  parameter int TICK_DIV   = 125,
  parameter int HALF_TICKS = 16,
  parameter int VOTE_N     = 3,
  parameter int MAX_DATA   = 64,
  parameter int SOF_LEN    = 3,
  parameter logic [SOF_LEN-1:0] SOF_PAT = 3'b001,
  localparam int DLEN_W = $clog2(MAX_DATA + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic                ready_i,
  output logic [FLAG_W-1:0]   flags_o,
  output logic [CMD_W-1:0]    cmd_o,
  output logic [PARM_W-1:0]   param_o,
  output logic [MAX_DATA-1:0] data_o,
  output logic [DLEN_W-1:0]   data_len_o,
  output logic                frame_valid_o,
  output logic                crc_err_o,
  output logic                sof_found_o
);
  localparam int MIN_BITS = HDR_W + CRC_W;
  localparam int MAX_BITS = MIN_BITS + MAX_DATA;
  localparam int CNT_W    = $clog2(MAX_BITS + 2);
  localparam int SCNT_W   = $clog2(SOF_LEN + 1);
  localparam logic [CNT_W-1:0]  END_FLAG = CNT_W'(FLAG_W);
  localparam logic [CNT_W-1:0]  END_CMD  = CNT_W'(FLAG_W + CMD_W);
  localparam logic [CNT_W-1:0]  END_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0]  MIN_C    = CNT_W'(MIN_BITS);
  localparam logic [CNT_W-1:0]  MAX_C    = CNT_W'(MAX_BITS);
  localparam logic [CNT_W-1:0]  OVF_C    = CNT_W'(MAX_BITS + 1);
  localparam logic [SCNT_W-1:0] SOF_LAST = SCNT_W'(SOF_LEN - 1);

  logic tick, filt, bstb, bval, viol, dec_clr;
  logic [CRC_W-1:0] crc_nx;

  cmdrx_tick #(.DIV(TICK_DIV)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  cmdrx_filter #(.VOTE_N(VOTE_N)) i_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_i), .filt_o(filt));

  cmdrx_mdec #(.HALF(HALF_TICKS)) i_mdec (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .din_i(filt), .clr_i(dec_clr),
    .bit_stb_o(bstb), .bit_o(bval), .viol_o(viol));

  frame_st_e            st_q, st_d;
  logic [SOF_LEN-1:0]   exp_q, exp_d;
  logic [SCNT_W-1:0]    scnt_q, scnt_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [CRC_W-1:0]     crc_q, crc_d;
  logic [FLAG_W-1:0]    cf_q, cf_d;
  logic [CMD_W-1:0]     cc_q, cc_d;
  logic [PARM_W-1:0]    cp_q, cp_d;
  logic [CRC_W-1:0]     dly_q, dly_d;
  logic [MAX_DATA-1:0]  dat_q, dat_d;
  logic [FLAG_W-1:0]    flags_q, flags_d;
  logic [CMD_W-1:0]     cmd_q, cmd_d;
  logic [PARM_W-1:0]    param_q, param_d;
  logic [MAX_DATA-1:0]  data_q, data_d;
  logic [DLEN_W-1:0]    dlen_q, dlen_d;
  logic                 vld_q, vld_d, err_q, err_d, sof_q, sof_d;
  logic [CNT_W-1:0]     dlen_full;
  logic                 frame_ok;

  cmdrx_crc i_crc (.crc_i(crc_q), .bit_i(bval), .crc_o(crc_nx));

  assign dec_clr   = (st_q == ST_CHECK) || (st_q == ST_HOLD) || (st_q == ST_ABORT);
  assign dlen_full = cnt_q - MIN_C;
  assign frame_ok  = (cnt_q >= MIN_C) && (cnt_q <= MAX_C) && (crc_q == CRC_RESIDUE);

  always_comb begin
    st_d = st_q;     exp_d = exp_q;     scnt_d = scnt_q;
    cnt_d = cnt_q;   crc_d = crc_q;
    cf_d = cf_q;     cc_d = cc_q;       cp_d = cp_q;
    dly_d = dly_q;   dat_d = dat_q;
    flags_d = flags_q; cmd_d = cmd_q;   param_d = param_q;
    data_d = data_q; dlen_d = dlen_q;
    vld_d = 1'b0;    err_d = 1'b0;      sof_d = sof_q;
    case (st_q)
      ST_HUNT: begin
        if (viol) begin
          st_d = ST_ABORT;
        end else if (bstb) begin
          if (bval != exp_q[SOF_LEN-1]) begin
            st_d = ST_ABORT;
          end else if (scnt_q == SOF_LAST) begin
            st_d  = ST_CAP;
            sof_d = 1'b1;
            crc_d = CRC_INIT;
            cnt_d = '0;
            cf_d = '0; cc_d = '0; cp_d = '0; dly_d = '0; dat_d = '0;
          end else begin
            exp_d  = exp_q << 1;
            scnt_d = scnt_q + 1'b1;
          end
        end
      end
      ST_CAP: begin
        if (viol) begin
          st_d = ST_CHECK;
        end else if (bstb) begin
          if (cnt_q < MAX_C) begin
            crc_d = crc_nx;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q < END_FLAG)     cf_d = {cf_q[FLAG_W-2:0], bval};
            else if (cnt_q < END_CMD) cc_d = {cc_q[CMD_W-2:0], bval};
            else if (cnt_q < END_HDR) cp_d = {cp_q[PARM_W-2:0], bval};
            else begin
              dly_d = {dly_q[CRC_W-2:0], bval};
              dat_d = {dat_q[MAX_DATA-2:0], dly_q[CRC_W-1]};
            end
          end else begin
            cnt_d = OVF_C;
          end
        end
      end
      ST_CHECK: begin
        st_d = ST_HOLD;
        if (frame_ok) begin
          vld_d   = 1'b1;
          flags_d = cf_q;
          cmd_d   = cc_q;
          param_d = cp_q;
          data_d  = dat_q;
          dlen_d  = dlen_full[DLEN_W-1:0];
        end else begin
          err_d = 1'b1;
        end
      end
      ST_HOLD: begin
        if (ready_i) begin
          st_d   = ST_HUNT;
          sof_d  = 1'b0;
          exp_d  = SOF_PAT;
          scnt_d = '0;
        end
      end
      default: begin
        st_d   = ST_HUNT;
        exp_d  = SOF_PAT;
        scnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_HUNT;  exp_q <= SOF_PAT;  scnt_q <= '0;
      cnt_q <= '0;      crc_q <= CRC_INIT;
      cf_q <= '0;       cc_q <= '0;        cp_q <= '0;
      dly_q <= '0;      dat_q <= '0;
      flags_q <= '0;    cmd_q <= '0;       param_q <= '0;
      data_q <= '0;     dlen_q <= '0;
      vld_q <= 1'b0;    err_q <= 1'b0;     sof_q <= 1'b0;
    end else begin
      st_q <= st_d;     exp_q <= exp_d;    scnt_q <= scnt_d;
      cnt_q <= cnt_d;   crc_q <= crc_d;
      cf_q <= cf_d;     cc_q <= cc_d;      cp_q <= cp_d;
      dly_q <= dly_d;   dat_q <= dat_d;
      flags_q <= flags_d; cmd_q <= cmd_d;  param_q <= param_d;
      data_q <= data_d; dlen_q <= dlen_d;
      vld_q <= vld_d;   err_q <= err_d;    sof_q <= sof_d;
    end
  end

  assign flags_o       = flags_q;
  assign cmd_o         = cmd_q;
  assign param_o       = param_q;
  assign data_o        = data_q;
  assign data_len_o    = dlen_q;
  assign frame_valid_o = vld_q;
  assign crc_err_o     = err_q;
  assign sof_found_o   = sof_q;
endmodule

// File: rtl/cmdrx_chk.sv
module cmdrx_chk #(
  parameter int MAX_DATA = 64,
  parameter int DLEN_W   = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ready_i,
  input logic [4:0]          flags_o,
  input logic [5:0]          cmd_o,
  input logic [7:0]          param_o,
  input logic [MAX_DATA-1:0] data_o,
  input logic [DLEN_W-1:0]   data_len_o,
  input logic                frame_valid_o,
  input logic                crc_err_o,
  input logic                sof_found_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (frame_valid_o || crc_err_o) pend_q <= 1'b1;
    else if (pend_q && ready_i)       pend_q <= 1'b0;
  end

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && crc_err_o));

  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  assert_err_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |=> !crc_err_o);

  assert_fields_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> ($stable(flags_o) && $stable(cmd_o) && $stable(param_o)
                   && $stable(data_o) && $stable(data_len_o)));

  assert_len_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_len_o <= DLEN_W'(MAX_DATA));

  assert_sof_before_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> sof_found_o);

  assert_wait_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !(frame_valid_o || crc_err_o));
endmodule

bind cmdrx_top cmdrx_chk #(.MAX_DATA(MAX_DATA), .DLEN_W(DLEN_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i),
  .flags_o(flags_o), .cmd_o(cmd_o), .param_o(param_o), .data_o(data_o),
  .data_len_o(data_len_o), .frame_valid_o(frame_valid_o),
  .crc_err_o(crc_err_o), .sof_found_o(sof_found_o));

// File: tb/test_cmdrx_top.sv
module test_cmdrx_top;
  localparam int TICK_DIV = 4;
  localparam int HALF     = 4;
  localparam int HB       = TICK_DIV * HALF;
  localparam int SOF_LEN  = 3;
  localparam logic [2:0] SOF_PAT = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic ready = 1'b1;
  logic [4:0]  flags;
  logic [5:0]  cmd;
  logic [7:0]  param;
  logic [63:0] data;
  logic [6:0]  dlen;
  logic vld, err, sof;

  always #4 clk = ~clk;

  cmdrx_top #(.TICK_DIV(TICK_DIV), .HALF_TICKS(HALF), .VOTE_N(3), .MAX_DATA(64),
              .SOF_LEN(SOF_LEN), .SOF_PAT(SOF_PAT)) i_cmdrx_top (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .ready_i(ready),
    .flags_o(flags), .cmd_o(cmd), .param_o(param), .data_o(data),
    .data_len_o(dlen), .frame_valid_o(vld), .crc_err_o(err), .sof_found_o(sof));

  int n_chk = 0, n_fail = 0;
  int n_vld = 0, n_err = 0;
  bit sof_seen = 0;
  logic fb [0:255];
  int fl = 0;

  always @(negedge clk) begin
    if (vld) n_vld++;
    if (err) n_err++;
    if (sof) sof_seen = 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic add(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      fb[fl] = v[i];
      fl++;
    end
  endtask

  task automatic start_frame(input logic [4:0] f, input logic [5:0] c, input logic [7:0] p);
    fl = 0;
    add(64'(SOF_PAT), SOF_LEN);
    add(64'(f), 5);
    add(64'(c), 6);
    add(64'(p), 8);
  endtask

  task automatic add_crc();
    logic [15:0] r;
    logic x;
    r = 16'hFFFF;
    for (int i = SOF_LEN; i < fl; i++) begin
      x = r[15] ^ fb[i];
      r = {r[14:0], 1'b0} ^ (x ? 16'h1021 : 16'h0000);
    end
    add(64'(r), 16);
  endtask

  task automatic drive_half(input logic v, input bit g);
    if (g) begin
      rx = v;  repeat (6) @(posedge clk);
      rx = !v; repeat (TICK_DIV - 1) @(posedge clk);
      rx = v;  repeat (HB - 6 - (TICK_DIV - 1)) @(posedge clk);
    end else begin
      rx = v;  repeat (HB) @(posedge clk);
    end
  endtask

  task automatic send(input bit glitch);
    sof_seen = 0;
    for (int i = 0; i < fl; i++) begin
      drive_half(fb[i], glitch && (i >= SOF_LEN));
      drive_half(!fb[i], glitch && (i >= SOF_LEN));
    end
  endtask

  task automatic idle();
    rx = 1'b1;
    repeat (10 * HB) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(vld == 0 && err == 0, "R1 strobes", {vld, err}, 0);
    check(sof == 0, "R1 sof_found", sof, 0);
    check(flags == 0 && cmd == 0 && param == 0, "R1 header fields", {flags, cmd, param}, 0);
    check(data == 0 && dlen == 0, "R1 data fields", data, 0);
  endtask

  task automatic t_good(input string tag, input logic [4:0] f, input logic [5:0] c,
                        input logic [7:0] p, input logic [63:0] d, input int n, input bit glitch);
    int v0, e0;
    logic [63:0] dexp;
    v0 = n_vld; e0 = n_err;
    start_frame(f, c, p);
    add(d, n);
    add_crc();
    send(glitch);
    @(negedge clk);
    check(n_vld == v0 && n_err == e0, {tag, " R11 no strobe before end marker"}, 64'(n_vld - v0), 0);
    idle();
    dexp = (n == 64) ? d : (d & ((64'd1 << n) - 1));
    check(n_vld == v0 + 1 && n_err == e0, {tag, " R5 one valid strobe"}, 64'(n_vld - v0), 1);
    check(sof_seen, {tag, " R3 sof_found raised"}, 64'(sof_seen), 1);
    check(flags == f && cmd == c && param == p, {tag, " R4 header split"},
          {flags, cmd, param}, {f, c, p});
    check(data == dexp, {tag, " R9 data right-aligned"}, data, dexp);
    check(dlen == 7'(n), {tag, " R9 data length"}, 64'(dlen), 64'(n));
  endtask

  task automatic expect_err(input string tag, input logic [18:0] hold_hdr, input logic [63:0] hold_data);
    check(n_err == 1 && n_vld == 0, {tag, " error strobe only"}, 64'(n_err), 1);
    check({flags, cmd, param} == hold_hdr && data == hold_data, {tag, " R6 fields kept"},
          {flags, cmd, param}, hold_hdr);
  endtask

  task automatic t_badcrc();
    int v0, e0;
    logic [18:0] h; logic [63:0] dd;
    h = {flags, cmd, param}; dd = data; v0 = n_vld; e0 = n_err;
    start_frame(5'h1F, 6'h3F, 8'hFF);
    add(64'hFFFF, 16);
    add_crc();
    fb[fl-1] = !fb[fl-1];
    send(0);
    idle();
    n_vld -= v0; n_err -= e0;
    expect_err("R6 bad check", h, dd);
    n_vld += v0; n_err += e0;
  endtask

  task automatic t_short();
    int v0, e0;
    logic [18:0] h; logic [63:0] dd;
    h = {flags, cmd, param}; dd = data; v0 = n_vld; e0 = n_err;
    start_frame(5'h02, 6'h05, 8'h40);
    add(64'hA5, 8);
    send(0);
    idle();
    n_vld -= v0; n_err -= e0;
    expect_err("R7 short frame", h, dd);
    n_vld += v0; n_err += e0;
  endtask

  task automatic t_long();
    int v0, e0;
    logic [18:0] h; logic [63:0] dd;
    h = {flags, cmd, param}; dd = data; v0 = n_vld; e0 = n_err;
    start_frame(5'h0C, 6'h12, 8'h99);
    add(64'h0123_4567_89AB_CDEF, 64);
    add(64'h1, 1);
    add_crc();
    send(0);
    idle();
    n_vld -= v0; n_err -= e0;
    expect_err("R8 oversized data", h, dd);
    n_vld += v0; n_err += e0;
  endtask

  task automatic t_badsof();
    int v0, e0;
    v0 = n_vld; e0 = n_err;
    fl = 0;
    add(64'b011, 3);
    send(0);
    idle();
    check(n_vld == v0 && n_err == e0, "R3 wrong start pattern not reported", 64'(n_vld - v0 + n_err - e0), 0);
    check(!sof_seen && sof == 0, "R3 sof_found stays low", 64'(sof_seen), 0);
  endtask

  task automatic t_ready();
    int v0, e0;
    ready = 1'b0;
    t_good("R10 first", 5'h11, 6'h21, 8'h3C, 64'hBEEF, 16, 0);
    v0 = n_vld; e0 = n_err;
    start_frame(5'h04, 6'h08, 8'h10);
    add(64'h1234, 16);
    add_crc();
    send(0);
    idle();
    check(n_vld == v0 && n_err == e0, "R10 frame ignored while waiting", 64'(n_vld - v0), 0);
    check(cmd == 6'h21 && data == 64'hBEEF, "R10 fields unchanged while waiting", 64'(cmd), 64'h21);
    ready = 1'b1;
    repeat (4) @(posedge clk);
    t_good("R10 after ready", 5'h07, 6'h2A, 8'h81, 64'h5A5A, 16, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (10 * HB) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_good("base", 5'h15, 6'h2A, 8'hA5, 64'hC3A5, 16, 0);
    t_good("empty data", 5'h0A, 6'h15, 8'h5A, 64'h0, 0, 0);
    t_good("full data", 5'h1E, 6'h01, 8'h80, 64'hF00D_CAFE_8001_2345, 64, 0);
    t_badcrc();
    t_short();
    t_long();
    t_badsof();
    t_good("R2 glitched", 5'h13, 6'h33, 8'h6E, 64'h96, 8, 1);
    t_ready();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
    $finish;
  end
endmodule